// File: doc/BRIEF.md
# Single-Cycle Rotate-Derived Shifter

This block shifts or rotates a 32-bit operand by any distance from 0 to 31 positions and returns the answer one clock after the request. It handles five operations: logical shift left, logical shift right, arithmetic shift right, rotate right and rotate left. The distance comes from one of two 5-bit inputs: an immediate field taken from an instruction, or the low bits of a register operand. A select input chooses between them.

The hardware holds a single rotation network that only turns right. It has five stages, and each stage either moves the word by its own power of two or passes it through. A left operation turns by the two's complement of the distance, which is (32 − k) mod 32. Shifts start from the rotated word and then apply a fill mask. The mask clears the bits that wrapped around, or, for the arithmetic case, puts copies of the sign bit in their place. The result register loads only on a valid request and keeps its value on other cycles.

Top module: `rot_shift_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low. The latency is exactly one clock.
- R2: Operation code 3'b000 (logical left): `result` equals the operand shifted left by k, with zeros entering at bit 0.
- R3: Operation code 3'b001 (logical right): `result` equals the operand shifted right by k, with zeros entering at bit 31.
- R4: Operation code 3'b010 (arithmetic right): `result` equals the operand shifted right by k, with copies of operand bit 31 filling the top k bits.
- R5: Operation code 3'b011 (rotate right): bits leaving at bit 0 re-enter at bit 31.
- R6: Operation code 3'b100 (rotate left): bits leaving at bit 31 re-enter at bit 0.
- R7: The distance k is `reg_amt` when `amt_from_reg` is 1 and `imm_amt` when it is 0. The other input has no effect on the result.
- R8: When k is 0, each of the five defined operation codes returns the operand unchanged.
- R9: Operation codes 3'b101, 3'b110 and 3'b111 give a result of zero for every operand and distance.
- R10: While reset is asserted and after it is released, `result` is zero and `out_valid` is low until the first valid request.
- R11: In a cycle with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Word to shift or rotate |
| imm_amt | input | 5 | Distance from the immediate field |
| reg_amt | input | 5 | Distance from the register operand |
| amt_from_reg | input | 1 | 1 selects reg_amt, 0 selects imm_amt |
| op | input | 3 | Operation code |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the hold of the result when no request arrives;
- the identity result for a zero distance;
- the zero result for unused operation codes;
- the fill bits at the edges of each shift (a cleared bit 31 for a logical right shift, a copied sign bit for an arithmetic right shift, a cleared bit 0 for a logical left shift).

The full bit-exact value of every operation needs the bench's reference model. This covers wrap-around order in the rotates, the exact boundary of the fill mask at each distance, and the rule that the unselected distance source is ignored. The bench applies directed corners (distances 0, 1, 16 and 31, and sign-bit patterns) and a long pseudo-random sweep.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        OP_SLL = 3'd0,
        OP_SRL = 3'd1,
        OP_SRA = 3'd2,
        OP_ROR = 3'd3,
        OP_ROL = 3'd4
    } rsu_op_e;

    function automatic logic op_is_left(input logic [2:0] code);
        return (code == OP_SLL) || (code == OP_ROL);
    endfunction

endpackage

// File: rtl/rsu_amount_sel.sv
module rsu_amount_sel #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] imm_amt,
    input  logic [AW-1:0] reg_amt,
    input  logic          amt_from_reg,
    input  logic          left_dir,
    output logic [AW-1:0] dist_k,
    output logic [AW-1:0] rot_amt
);
    always_comb begin
        dist_k  = amt_from_reg ? reg_amt : imm_amt;
        // left by k == right by (2^AW - k) mod 2^AW
        rot_amt = left_dir ? (AW'(0) - dist_k) : dist_k;
    end
endmodule

// File: rtl/rsu_rotr_net.sv
module rsu_rotr_net #(
    parameter int unsigned W  = 32,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][W-1:STEP]} : stg[s];
    end

    assign dout = stg[AW];
endmodule

// File: rtl/rsu_fill_mask.sv
module rsu_fill_mask #(
    parameter int unsigned W  = 32,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0] dist_k,
    input  logic          left_dir,
    output logic [W-1:0]  keep
);
    logic [AW:0] k_ext;
    assign k_ext = {1'b0, dist_k};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [AW:0] IDX = (AW+1)'(i);
        localparam logic [AW:0] LIM = (AW+1)'(W);
        // left: low k bits are wrapped; right: top k bits are wrapped
        assign keep[i] = left_dir ? (IDX >= k_ext) : ((IDX + k_ext) < LIM);
    end
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit #(
    parameter int unsigned W  = rsu_pkg::WORD_W,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] imm_amt,
    input  logic [AW-1:0] reg_amt,
    input  logic          amt_from_reg,
    input  logic [2:0]    op,
    output logic          out_valid,
    output logic [W-1:0]  result
);
    import rsu_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } state_t;

    state_t        st_d, st_q;
    logic          left_dir;
    logic [AW-1:0] dist_k;
    logic [AW-1:0] rot_amt;
    logic [W-1:0]  rotated;
    logic [W-1:0]  keep;
    logic [W-1:0]  shaped;

    assign left_dir = op_is_left(op);

    rsu_amount_sel #(.AW(AW)) i_amt (
        .imm_amt      (imm_amt),
        .reg_amt      (reg_amt),
        .amt_from_reg (amt_from_reg),
        .left_dir     (left_dir),
        .dist_k       (dist_k),
        .rot_amt      (rot_amt)
    );

    rsu_rotr_net #(.W(W)) i_rot (
        .din  (operand),
        .amt  (rot_amt),
        .dout (rotated)
    );

    rsu_fill_mask #(.W(W)) i_mask (
        .dist_k   (dist_k),
        .left_dir (left_dir),
        .keep     (keep)
    );

    always_comb begin
        case (rsu_op_e'(op))
            OP_SLL,
            OP_SRL:  shaped = rotated & keep;
            OP_SRA:  shaped = (rotated & keep) | ({W{operand[W-1]}} & ~keep);
            OP_ROR,
            OP_ROL:  shaped = rotated;
            default: shaped = '0;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = shaped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
    parameter int unsigned W  = 32,
    localparam int unsigned AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  operand,
    input logic [AW-1:0] imm_amt,
    input logic [AW-1:0] reg_amt,
    input logic          amt_from_reg,
    input logic [2:0]    op,
    input logic          out_valid,
    input logic [W-1:0]  result
);
    logic [AW-1:0] k_sel;
    assign k_sel = amt_from_reg ? reg_amt : imm_amt;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && k_sel != '0) |=> !result[0]); // R2
    AST_SRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1 && k_sel != '0) |=> !result[W-1]); // R3
    AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2) |=> (result[W-1] == $past(operand[W-1]))); // R4
    AST_ZERO_DIST_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 3'd4 && k_sel == '0) |=> (result == $past(operand))); // R8
    AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> (result == '0)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R11
endmodule

bind rot_shift_unit rsu_checker #(.W(W)) i_rsu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .operand      (operand),
    .imm_amt      (imm_amt),
    .reg_amt      (reg_amt),
    .amt_from_reg (amt_from_reg),
    .op           (op),
    .out_valid    (out_valid),
    .result       (result)
);

// File: tb/test_rot_shift_unit.sv
module test_rot_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  imm_amt = '0;
    logic [4:0]  reg_amt = '0;
    logic        amt_from_reg = 1'b0;
    logic [2:0]  op = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    logic        exp_vld = 1'b0;
    logic [31:0] exp_res = '0;
    string       exp_tag = "R10";
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rot_shift_unit i_rot_shift_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .operand      (operand),
        .imm_amt      (imm_amt),
        .reg_amt      (reg_amt),
        .amt_from_reg (amt_from_reg),
        .op           (op),
        .out_valid    (out_valid),
        .result       (result)
    );

    function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] x, input int k);
        logic [63:0] dbl;
        dbl = {x, x};
        case (c)
            3'd0: return x << k;
            3'd1: return x >> k;
            3'd2: return $unsigned($signed(x) >>> k);
            3'd3: begin dbl = dbl >> k; return dbl[31:0]; end
            3'd4: begin dbl = dbl << k; return dbl[63:32]; end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c, input int k, input logic src);
        string t;
        case (c)
            3'd0: t = "R2";
            3'd1: t = "R3";
            3'd2: t = "R4";
            3'd3: t = "R5";
            3'd4: t = "R6";
            default: t = "R9";
        endcase
        if (k == 0 && c <= 3'd4) t = {t, "/R8"};
        if (src) t = {t, "/R7"};
        return t;
    endfunction

    task automatic compare();
        n_vec++;
        if (out_valid !== exp_vld) begin
            n_fail++;
            $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, exp_vld);
        end
        if (result !== exp_res) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
        end
    endtask

    // drive one cycle of stimulus at a falling edge after checking the last one
    task automatic step(input logic v, input logic [2:0] c, input logic [31:0] x,
                        input logic [4:0] ki, input logic [4:0] kr, input logic src);
        int k;
        @(negedge clk);
        compare();
        in_valid = v; op = c; operand = x; imm_amt = ki; reg_amt = kr; amt_from_reg = src;
        k = src ? int'(kr) : int'(ki);
        exp_vld = v;
        if (v) begin
            exp_res = model(c, x, k);
            exp_tag = tag_of(c, k, src);
        end else begin
            exp_tag = "R11";
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h1234_5678; pats[3] = 32'h7FFF_FFFE;
        repeat (3) @(negedge clk);
        compare();                       // R10: held in reset
        rst_n = 1'b1;
        step(1'b0, 3'd0, 32'hDEAD_BEEF, 5'd3, 5'd0, 1'b0);   // R10/R11 idle after reset
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                step(1'b1, 3'(c), pats[p], 5'd0, 5'd17, 1'b0);
                step(1'b1, 3'(c), pats[p], 5'd1, 5'd9, 1'b0);
                step(1'b1, 3'(c), pats[p], 5'd22, 5'd31, 1'b1);
                step(1'b1, 3'(c), pats[p], 5'd5, 5'd16, 1'b1);
                step(1'b0, 3'(c), ~pats[p], 5'd7, 5'd7, 1'b0);
            end
        end
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3:0] != 4'd0, lfsr[10:8], lfsr ^ 32'h5A5A_0F0F,
                 lfsr[15:11], lfsr[20:16], lfsr[7]);
        end
        step(1'b0, 3'd0, '0, '0, '0, 1'b0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule